// File: doc/BRIEF.md
# Status Word Width and Endianness Fields

This block keeps the part of a machine-level status word that sets the register width and the data byte order of the lower privilege levels. It holds the current machine width, the supervisor and user width fields, and the three endianness bits (machine, supervisor, user). Every write is filtered so that each field only ever holds a legal value. Elaboration parameters choose whether the supervisor and user levels exist and which widths the core supports. They also choose, for each lower-level field, whether it is writable or a read-only copy of another field.

A privileged-register write port supplies an enable and an 8-bit data word. The current field values come back on a read port. A separate strobe carries a new machine width. When the machine width changes, the lower-level width fields are legalized again: they are widened when the machine leaves 32-bit mode and clamped when it narrows. The effective width and byte order of each level are driven out for the datapath.

Top module: `psw_xlbe_unit`

## Requirements
- R1: After reset, the machine width and every writable width field hold the widest supported encoding, and every writable endianness bit is 0 (little-endian).
- R2: Width encodings are 1 = 32-bit, 2 = 64-bit and 3 = 128-bit. In the data word, bits [1:0] are the user width, [3:2] the supervisor width, bit 4 the user byte order, bit 5 the supervisor byte order, bit 6 the machine byte order, and bit 7 reads 0. A write of a supported encoding that is no wider than the governing width takes effect at the next clock edge. The governing width is the supervisor width for the user field, or the machine width when no supervisor level exists, and it is the machine width for the supervisor field.
- R3: A write of encoding 0, of an unsupported encoding, or of a width wider than the governing width leaves the width field unchanged.
- R4: The supervisor width is never wider than the machine width, and the user width is never wider than the supervisor width. When the machine width narrows, any field that would become too wide is clamped to the widest supported width that still fits.
- R5: When the machine width changes from 32 bits to a wider supported width, each writable lower-level width field takes the widest supported width not wider than its new governing width. A width-change request with an unsupported encoding is ignored.
- R6: When a width change and a register write fall in the same cycle, the write is judged against the new widths. A legal write wins over the automatic widening or clamping.
- R7: Each writable endianness bit takes the written value at the next edge; 1 means big-endian.
- R8: Without a supervisor level, the supervisor width and byte-order fields read 0. Without a user level, the user fields read 0. Writes to these fields have no effect.
- R9: A read-only supervisor width field always equals the machine width and ignores writes.
- R10: A read-only user width field always equals either the machine width or the supervisor width, as configured, and ignores writes.
- R11: A read-only supervisor byte-order bit copies the machine bit, and a read-only user byte-order bit copies either the machine bit or the supervisor bit. The copy follows its source in the same cycle, and writes to the copy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data, field layout as in R2 |
| mxl_chg | input | 1 | Machine width change strobe |
| mxl_new | input | 2 | New machine width encoding |
| rd_data | output | 8 | Current field values, layout as in R2 |
| mxl_o | output | 2 | Effective machine width |
| sxl_o | output | 2 | Effective supervisor width |
| uxl_o | output | 2 | Effective user width |
| mbe_o | output | 1 | Machine byte order |
| sbe_o | output | 1 | Supervisor byte order |
| ube_o | output | 1 | User byte order |

## Verification
The assertions assume that reset is released cleanly and that `wr_data` and `mxl_new` are fully driven (no X) whenever their strobes are high. They place no limit on the encodings offered, so the stimulus deliberately sends encoding 0, unsupported encodings, over-wide writes and width changes in both directions, including in the same cycle as a write. Random cycles drawn from a fixed seed cover the overlap cases. Directed steps force the narrowing, widening and same-cycle orderings in a known sequence. Three instances with different configurations (all writable, all mirrors, no lower levels) share the same stimulus.

// File: rtl/psw_xl_pkg.sv
package psw_xl_pkg;

  localparam int XL_W    = 2;
  localparam int RD_W    = 8;
  localparam int UXL_LSB = 0;
  localparam int SXL_LSB = 2;
  localparam int UBE_BIT = 4;
  localparam int SBE_BIT = 5;
  localparam int MBE_BIT = 6;

  typedef logic [XL_W-1:0] xl_t;

  // true when encoding v is nonzero and enabled in the support mask
  function automatic logic xl_sup(input logic [2:0] sup, input xl_t v);
    logic r;
    r = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      if (int'(v) == i && sup[i-1]) r = 1'b1;
    end
    return r;
  endfunction

  // widest supported encoding that is not wider than cap
  function automatic xl_t xl_widest(input logic [2:0] sup, input xl_t cap);
    xl_t r;
    r = '0;
    for (int i = 1; i <= 3; i++) begin
      if (sup[i-1] && i <= int'(cap)) r = xl_t'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/psw_xl_field.sv
module psw_xl_field
  import psw_xl_pkg::*;
#(
  parameter bit         PRESENT = 1'b1,
  parameter bit         MIRROR  = 1'b0,
  parameter logic [2:0] SUP     = 3'b011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  xl_t  wr_val,
  input  xl_t  cap,
  input  logic widen,
  input  xl_t  src_q,
  input  xl_t  src_nx,
  output xl_t  q,
  output xl_t  nx
);

  generate
    if (!PRESENT) begin : g_absent
      logic unused_absent;
      assign unused_absent = ^{clk, rst_n, wr_en, wr_val, cap, widen, src_q, src_nx};
      assign q  = '0;
      assign nx = '0;
    end else if (MIRROR) begin : g_mirror
      logic unused_mirror;
      assign unused_mirror = ^{clk, rst_n, wr_en, wr_val, cap, widen};
      assign q  = src_q;
      assign nx = src_nx;
    end else begin : g_reg
      xl_t  q_r;
      xl_t  nx_c;
      logic load;
      logic unused_src;
      assign unused_src = ^{src_q, src_nx};

      always_comb begin
        nx_c = q_r;
        if (widen || (q_r > cap)) nx_c = xl_widest(SUP, cap);
        if (wr_en && xl_sup(SUP, wr_val) && (wr_val <= cap)) nx_c = wr_val;
      end

      assign load = (nx_c != q_r);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_r <= xl_widest(SUP, 2'd3);
        else if (load) q_r <= nx_c;
      end

      assign q  = q_r;
      assign nx = nx_c;
    end
  endgenerate

endmodule

// File: rtl/psw_be_field.sv
module psw_be_field #(
  parameter bit PRESENT = 1'b1,
  parameter bit MIRROR  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic src,
  output logic q
);

  generate
    if (!PRESENT) begin : g_absent
      logic unused_absent;
      assign unused_absent = ^{clk, rst_n, wr_en, wr_bit, src};
      assign q = 1'b0;
    end else if (MIRROR) begin : g_mirror
      logic unused_mirror;
      assign unused_mirror = ^{clk, rst_n, wr_en, wr_bit};
      assign q = src;
    end else begin : g_reg
      logic q_r;
      logic unused_src;
      assign unused_src = src;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_r <= 1'b0;
        else if (wr_en) q_r <= wr_bit;
      end

      assign q = q_r;
    end
  endgenerate

endmodule

// File: rtl/psw_xlbe_unit.sv
module psw_xlbe_unit
  import psw_xl_pkg::*;
#(
  parameter bit         HAS_S   = 1'b1,
  parameter bit         HAS_U   = 1'b1,
  parameter logic [2:0] XL_SUP  = 3'b011,
  parameter bit         SXL_RO  = 1'b0,
  parameter int         UXL_SRC = 0,
  parameter bit         SBE_RO  = 1'b0,
  parameter int         UBE_SRC = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RD_W-1:0] wr_data,
  input  logic            mxl_chg,
  input  logic [XL_W-1:0] mxl_new,
  output logic [RD_W-1:0] rd_data,
  output logic [XL_W-1:0] mxl_o,
  output logic [XL_W-1:0] sxl_o,
  output logic [XL_W-1:0] uxl_o,
  output logic            mbe_o,
  output logic            sbe_o,
  output logic            ube_o
);

  localparam xl_t MXL_RST    = xl_widest(XL_SUP, 2'd3);
  localparam bit  UXL_FROM_S = (UXL_SRC == 2) && HAS_S;
  localparam bit  UBE_FROM_S = (UBE_SRC == 2) && HAS_S;

  xl_t  mxl_q, mxl_nx;
  logic mxl_ok, widen;
  xl_t  sxl_q, sxl_nx, uxl_q, uxl_nx;
  xl_t  uxl_src_q, uxl_src_nx, uxl_cap;
  logic mbe_q, sbe_q, ube_q, ube_src;

  // machine width: next-state and register
  always_comb begin
    mxl_ok = mxl_chg && xl_sup(XL_SUP, mxl_new);
    mxl_nx = mxl_ok ? mxl_new : mxl_q;
    widen  = mxl_ok && (mxl_q == 2'd1) && (mxl_new > 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mxl_q <= MXL_RST;
    else if (mxl_ok) mxl_q <= mxl_nx;
  end

  psw_xl_field #(.PRESENT(HAS_S), .MIRROR(SXL_RO), .SUP(XL_SUP)) u_sxl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_val(wr_data[SXL_LSB +: XL_W]), .cap(mxl_nx), .widen(widen),
    .src_q(mxl_q), .src_nx(mxl_nx), .q(sxl_q), .nx(sxl_nx)
  );

  assign uxl_src_q  = UXL_FROM_S ? sxl_q  : mxl_q;
  assign uxl_src_nx = UXL_FROM_S ? sxl_nx : mxl_nx;
  assign uxl_cap    = HAS_S ? sxl_nx : mxl_nx;

  psw_xl_field #(.PRESENT(HAS_U), .MIRROR(UXL_SRC != 0), .SUP(XL_SUP)) u_uxl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_val(wr_data[UXL_LSB +: XL_W]), .cap(uxl_cap), .widen(widen),
    .src_q(uxl_src_q), .src_nx(uxl_src_nx), .q(uxl_q), .nx(uxl_nx)
  );

  psw_be_field #(.PRESENT(1'b1), .MIRROR(1'b0)) u_mbe (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_bit(wr_data[MBE_BIT]), .src(1'b0), .q(mbe_q)
  );

  psw_be_field #(.PRESENT(HAS_S), .MIRROR(SBE_RO)) u_sbe (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_bit(wr_data[SBE_BIT]), .src(mbe_q), .q(sbe_q)
  );

  assign ube_src = UBE_FROM_S ? sbe_q : mbe_q;

  psw_be_field #(.PRESENT(HAS_U), .MIRROR(UBE_SRC != 0)) u_ube (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_bit(wr_data[UBE_BIT]), .src(ube_src), .q(ube_q)
  );

  logic unused_nx;
  assign unused_nx = ^uxl_nx;

  always_comb begin
    rd_data = '0;
    rd_data[UXL_LSB +: XL_W] = uxl_q;
    rd_data[SXL_LSB +: XL_W] = sxl_q;
    rd_data[UBE_BIT]         = ube_q;
    rd_data[SBE_BIT]         = sbe_q;
    rd_data[MBE_BIT]         = mbe_q;
  end

  assign mxl_o = mxl_q;
  assign sxl_o = sxl_q;
  assign uxl_o = uxl_q;
  assign mbe_o = mbe_q;
  assign sbe_o = sbe_q;
  assign ube_o = ube_q;

endmodule

// File: rtl/psw_xlbe_chk.sv
module psw_xlbe_chk
  import psw_xl_pkg::*;
#(
  parameter bit         HAS_S   = 1'b1,
  parameter bit         HAS_U   = 1'b1,
  parameter logic [2:0] XL_SUP  = 3'b011,
  parameter bit         SBE_RO  = 1'b0,
  parameter int         UBE_SRC = 0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [RD_W-1:0] wr_data,
  input logic            mxl_chg,
  input logic [XL_W-1:0] mxl_new,
  input logic [XL_W-1:0] mxl_o,
  input logic [XL_W-1:0] sxl_o,
  input logic [XL_W-1:0] uxl_o,
  input logic            mbe_o,
  input logic            sbe_o,
  input logic            ube_o
);

  logic unused_chk;
  assign unused_chk = ^{wr_data, uxl_o, mbe_o, sbe_o, ube_o};

  // R5
  mxl_bad_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mxl_chg && !xl_sup(XL_SUP, mxl_new)) |=> $stable(mxl_o));

  generate
    if (HAS_S) begin : g_s
      // R4
      sxl_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sxl_o <= mxl_o);
      // R5
      sxl_widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mxl_chg && !wr_en && xl_sup(XL_SUP, mxl_new) && mxl_o == 2'd1 && mxl_new > 2'd1)
        |=> sxl_o == xl_widest(XL_SUP, mxl_o));
      // R3
      sxl_bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mxl_chg && !xl_sup(XL_SUP, wr_data[SXL_LSB +: XL_W])) |=> $stable(sxl_o));
    end else begin : g_no_s
      // R8
      no_s_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sxl_o == 2'd0 && !sbe_o);
    end

    if (HAS_S && HAS_U) begin : g_su
      // R4
      uxl_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uxl_o <= sxl_o);
    end

    if (!HAS_U) begin : g_no_u
      // R8
      no_u_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uxl_o == 2'd0 && !ube_o);
    end

    if (HAS_S && SBE_RO) begin : g_sbe_m
      // R11
      sbe_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sbe_o == mbe_o);
    end

    if (HAS_U && UBE_SRC == 1) begin : g_ube_m
      // R11
      ube_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ube_o == mbe_o);
    end
  endgenerate

endmodule

bind psw_xlbe_unit psw_xlbe_chk #(
  .HAS_S(HAS_S), .HAS_U(HAS_U), .XL_SUP(XL_SUP), .SBE_RO(SBE_RO), .UBE_SRC(UBE_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .mxl_chg(mxl_chg), .mxl_new(mxl_new), .mxl_o(mxl_o), .sxl_o(sxl_o),
  .uxl_o(uxl_o), .mbe_o(mbe_o), .sbe_o(sbe_o), .ube_o(ube_o)
);

// File: tb/tb_psw_xlbe_unit.sv
`timescale 1ns/1ps
module tb_psw_xlbe_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       mxl_chg;
  logic [1:0] mxl_new;

  logic [7:0] rd_a, rd_m, rd_n;
  logic [1:0] mx_a, sx_a, ux_a, mx_m, sx_m, ux_m, mx_n, sx_n, ux_n;
  logic       mb_a, sb_a, ub_a, mb_m, sb_m, ub_m, mb_n, sb_n, ub_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // all fields writable, widths 32/64
  psw_xlbe_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mxl_chg(mxl_chg), .mxl_new(mxl_new), .rd_data(rd_a),
    .mxl_o(mx_a), .sxl_o(sx_a), .uxl_o(ux_a), .mbe_o(mb_a), .sbe_o(sb_a), .ube_o(ub_a));

  // all lower fields read-only copies, widths 32/64/128
  psw_xlbe_unit #(.XL_SUP(3'b111), .SXL_RO(1'b1), .UXL_SRC(2), .SBE_RO(1'b1), .UBE_SRC(2)) dut_m (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mxl_chg(mxl_chg), .mxl_new(mxl_new), .rd_data(rd_m),
    .mxl_o(mx_m), .sxl_o(sx_m), .uxl_o(ux_m), .mbe_o(mb_m), .sbe_o(sb_m), .ube_o(ub_m));

  // no supervisor, no user level
  psw_xlbe_unit #(.HAS_S(1'b0), .HAS_U(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mxl_chg(mxl_chg), .mxl_new(mxl_new), .rd_data(rd_n),
    .mxl_o(mx_n), .sxl_o(sx_n), .uxl_o(ux_n), .mbe_o(mb_n), .sbe_o(sb_n), .ube_o(ub_n));

  // reference state
  logic [1:0] e_mxl, e_sxl, e_uxl, e2_mxl;
  logic       e_mbe, e_sbe, e_ube;

  function automatic bit sup(input logic [2:0] s, input logic [1:0] v);
    return (v != 2'd0) && s[v - 2'd1];
  endfunction

  function automatic logic [1:0] wle(input logic [2:0] s, input logic [1:0] c);
    logic [1:0] r = 2'd0;
    for (int i = 1; i <= 3; i++) if (s[i-1] && i <= int'(c)) r = 2'(i);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " main"}, {mx_a, sx_a, ux_a, mb_a, sb_a, ub_a, rd_a},
        {e_mxl, e_sxl, e_uxl, e_mbe, e_sbe, e_ube,
         1'b0, e_mbe, e_sbe, e_ube, e_sxl, e_uxl});
    // R9 R10 R11: copies follow their sources
    chk({tag, " R9 R10 R11 mirror"}, {mx_m, sx_m, ux_m, mb_m, sb_m, ub_m, rd_m},
        {e2_mxl, e2_mxl, e2_mxl, e_mbe, e_mbe, e_mbe,
         1'b0, e_mbe, e_mbe, e_mbe, e2_mxl, e2_mxl});
    // R8: absent levels read zero
    chk({tag, " R8 absent"}, {mx_n, sx_n, ux_n, mb_n, sb_n, ub_n, rd_n},
        {e_mxl, 2'd0, 2'd0, e_mbe, 1'b0, 1'b0, 1'b0, e_mbe, 6'd0});
  endtask

  task automatic step(input logic we, input logic [7:0] wd, input logic mc,
                      input logic [1:0] mn, input string tag);
    logic [1:0] nm, ns, nu, nm2;
    logic       wid;
    nm  = (mc && sup(3'b011, mn)) ? mn : e_mxl;
    wid = mc && sup(3'b011, mn) && e_mxl == 2'd1 && mn > 2'd1;
    ns  = e_sxl;
    if (wid || ns > nm) ns = wle(3'b011, nm);
    if (we && sup(3'b011, wd[3:2]) && wd[3:2] <= nm) ns = wd[3:2];
    nu  = e_uxl;
    if (wid || nu > ns) nu = wle(3'b011, ns);
    if (we && sup(3'b011, wd[1:0]) && wd[1:0] <= ns) nu = wd[1:0];
    nm2 = (mc && mn != 2'd0) ? mn : e2_mxl;
    wr_en = we; wr_data = wd; mxl_chg = mc; mxl_new = mn;
    @(posedge clk);
    #1;
    e_mxl = nm; e_sxl = ns; e_uxl = nu; e2_mxl = nm2;
    if (we) begin
      e_mbe = wd[6]; e_sbe = wd[5]; e_ube = wd[4];
    end
    wr_en = 1'b0; mxl_chg = 1'b0;
    compare(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; mxl_chg = 1'b0; mxl_new = '0;
    void'($urandom(32'd20417));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state, widest widths, little-endian
    e_mxl = 2'd2; e_sxl = 2'd2; e_uxl = 2'd2; e2_mxl = 2'd3;
    e_mbe = 1'b0; e_sbe = 1'b0; e_ube = 1'b0;
    chk("R1 reset rd_data", rd_a, 8'h0A);
    chk("R1 reset mirror rd_data", rd_m, 8'h0F);
    compare("R1 reset");

    step(1'b1, 8'h05, 1'b0, 2'd0, "R2 write 32/32");
    step(1'b1, 8'h0D, 1'b0, 2'd0, "R3 unsupported sxl");
    step(1'b1, 8'h04, 1'b0, 2'd0, "R3 zero uxl");
    step(1'b1, 8'h06, 1'b0, 2'd0, "R3 uxl wider than sxl");
    step(1'b1, 8'h0A, 1'b0, 2'd0, "R2 write 64/64");
    step(1'b0, 8'h00, 1'b1, 2'd1, "R4 narrow clamp");
    step(1'b0, 8'h00, 1'b1, 2'd2, "R5 widen from 32");
    step(1'b0, 8'h00, 1'b1, 2'd0, "R5 bad width ignored");
    step(1'b0, 8'h00, 1'b1, 2'd3, "R5 unsupported width ignored");
    step(1'b0, 8'h00, 1'b1, 2'd1, "R4 narrow again");
    step(1'b1, 8'h05, 1'b1, 2'd2, "R6 write beats widen");
    step(1'b1, 8'h0A, 1'b1, 2'd1, "R6 write judged on new width");
    step(1'b1, 8'h75, 1'b0, 2'd0, "R7 big-endian all");
    step(1'b1, 8'h45, 1'b0, 2'd0, "R11 machine only");
    step(1'b1, 8'h05, 1'b0, 2'd0, "R7 clear");

    for (int k = 0; k < 600; k++) begin
      step(1'($urandom % 2), 8'($urandom), ($urandom % 4) == 0, 2'($urandom),
           "R2 R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule